// File: doc/BRIEF.md
# Baseband Hang Pattern Matcher

This block decides whether a receive baseband has locked up, judging from one 32-bit observation word that the baseband publishes. When a check is requested, the block captures the word. It then watches the same bus for a fixed number of further samples. A word that changes at any point during that window means the baseband is still alive, and no baseband hang is reported.

A word that holds steady for the whole window is tested against four fixed mask/value signatures in a set priority order. Each signature identifies one class of hang. The class is reported as a one-hot bit in a small result vector.

The same result vector also carries the code from a companion MAC hang check, which lives outside this block. The two checks are gated as follows. The MAC check is started only when it was requested and the baseband part of the result is zero. A detected baseband hang therefore suppresses the MAC check. The final result appears together with a one-cycle completion pulse.

Top module: `bbh_matcher`

## Requirements
- R1: After reset, and after a reset applied during a check, `done_o`, `mac_chk_o` and `result_o` are all zero.
- R2: The word captured on the accepting `req_i` edge is compared with the bus on each of the following `NSAMP` (50) clock edges. If any of those samples differs, the baseband bits `result_o[2:0]` are zero.
- R3: A steady word with `(w & 0x7E000B00) == 0x1E000000` sets `result_o[0]`, the radar-detection hang class.
- R4: A steady word with `(w & 0x7E000B00) == 0x52000B00` sets `result_o[1]`, the reduced-spacing hang class.
- R5: A steady word with `(w & 0x7E000B00) == 0x18000B00` sets `result_o[2]`, the receive-clear hang class.
- R6: A steady word with `(w & 0x7E7FFFEF) == 0x00702400` also sets `result_o[2]`.
- R7: Signatures are tested in the order R3, R4, R5, R6, and the first match decides the class. At most one of `result_o[2:0]` is ever set.
- R8: A steady word that matches no signature leaves `result_o[2:0]` at zero.
- R9: When `result_o[2:0]` is nonzero, the MAC check is skipped. `mac_chk_o` stays low and `result_o[4:3]` is zero.
- R10: When `mac_en_i` was set and `result_o[2:0]` is zero, `mac_chk_o` pulses for one cycle, one cycle before `done_o`. In that cycle `mac_code_i` is copied into `result_o[4:3]`. If `mac_en_i` was clear, `result_o[4:3]` is zero.
- R11: `done_o` is a one-cycle pulse. It is sampled high `NSAMP+1` cycles after the accepting `req_i` edge when `bb_en_i` was set, and 1 cycle after it otherwise. `result_o` is valid in that cycle.
- R12: A `req_i` pulse while a check is in progress is ignored. It neither restarts nor alters that check.
- R13: With `bb_en_i` clear at request time, no stability window runs and `result_o[2:0]` is zero whatever the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a check (accepted only when idle) |
| bb_en_i | input | 1 | Run the baseband check, captured with req_i |
| mac_en_i | input | 1 | Allow the MAC check, captured with req_i |
| obs_i | input | 32 | Baseband observation word |
| mac_code_i | input | 2 | Result of the companion MAC check, taken while mac_chk_o is high |
| mac_chk_o | output | 1 | MAC check is being run this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 5 | {MAC code, one-hot baseband class} |

## Verification
The embedded properties check several rules on every cycle. The completion pulse is always a single cycle, and a MAC strobe is always followed by completion. The baseband class is never more than one-hot, and a nonzero class never coexists with MAC bits. A disabled baseband check never yields a class. While a window is running, the captured word and the request flags hold still, and a seen mismatch stays latched.

Other behaviour can only be shown by the bench's scenarios. These include the exact latency, the mapping of each signature (including words with don't-care bits set) to its class, and the loss of a hang when one sample differs at the first, a middle or the last position. They also include the MAC code merging, a request ignored mid-window, and a reset during a window.

// File: rtl/bbh_pkg.sv
package bbh_pkg;

  localparam int OBS_W    = 32;
  localparam int NSIG     = 4;
  localparam int BB_CLS_W = 3;

  // one-hot hang classes
  localparam logic [BB_CLS_W-1:0] CLS_RADAR = 3'b001;
  localparam logic [BB_CLS_W-1:0] CLS_SPACE = 3'b010;
  localparam logic [BB_CLS_W-1:0] CLS_RXCLR = 3'b100;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WATCH  = 2'd1,
    ST_DECIDE = 2'd2
  } bbh_state_e;

  // signature table, index order is the priority order
  function automatic logic [OBS_W-1:0] sig_mask(input int idx);
    case (idx)
      0, 1, 2: sig_mask = 32'h7E00_0B00;
      default: sig_mask = 32'h7E7F_FFEF;
    endcase
  endfunction

  function automatic logic [OBS_W-1:0] sig_value(input int idx);
    case (idx)
      0:       sig_value = 32'h1E00_0000;
      1:       sig_value = 32'h5200_0B00;
      2:       sig_value = 32'h1800_0B00;
      default: sig_value = 32'h0070_2400;
    endcase
  endfunction

  function automatic logic [BB_CLS_W-1:0] sig_class(input int idx);
    case (idx)
      0:       sig_class = CLS_RADAR;
      1:       sig_class = CLS_SPACE;
      default: sig_class = CLS_RXCLR;
    endcase
  endfunction

endpackage

// File: rtl/bbh_window.sv
module bbh_window #(
  parameter int OBS_W = 32,
  parameter int NSAMP = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             active_i,
  input  logic [OBS_W-1:0] obs_i,
  output logic [OBS_W-1:0] word_o,
  output logic             last_o,
  output logic             steady_o
);

  localparam int CNT_W = $clog2(NSAMP + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NSAMP - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OBS_W-1:0] word_q, word_d;
  logic             miss_q, miss_d;
  logic             load_en;

  assign load_en = start_i | active_i;

  always_comb begin
    cnt_d  = cnt_q;
    word_d = word_q;
    miss_d = miss_q;
    if (start_i) begin
      cnt_d  = '0;
      word_d = obs_i;
      miss_d = 1'b0;
    end else if (active_i) begin
      cnt_d  = cnt_q + CNT_W'(1);
      miss_d = miss_q | (obs_i != word_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
      miss_q <= 1'b0;
    end else if (load_en) begin
      cnt_q  <= cnt_d;
      word_q <= word_d;
      miss_q <= miss_d;
    end
  end

  assign word_o   = word_q;
  assign last_o   = active_i & (cnt_q == LAST_CNT);
  assign steady_o = ~miss_q;

  // R2: captured word is held for the whole window
  a_r2_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |=> $stable(word_q));

  // R2: once a difference is seen it stays recorded
  a_r2_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && miss_q) |=> miss_q);

  // R11: sample counter never passes the window length
  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (cnt_q <= LAST_CNT));

endmodule

// File: rtl/bbh_sig_match.sv
module bbh_sig_match
  import bbh_pkg::*;
(
  input  logic [OBS_W-1:0]    word_i,
  input  logic                en_i,
  output logic [BB_CLS_W-1:0] cls_o
);

  logic [NSIG-1:0] hit;

  for (genvar g = 0; g < NSIG; g++) begin : g_sig
    assign hit[g] = ((word_i & sig_mask(g)) == sig_value(g));
  end

  // lowest index wins: scan from the back so earlier entries overwrite
  always_comb begin
    cls_o = '0;
    if (en_i) begin
      for (int i = NSIG - 1; i >= 0; i--) begin
        if (hit[i]) cls_o = sig_class(i);
      end
    end
  end

  // R7: reported class is at most one-hot
  always_comb begin
    a_r7_cls_onehot: assert ($onehot0(cls_o));
  end

endmodule

// File: rtl/bbh_combine.sv
module bbh_combine
  import bbh_pkg::*;
#(
  parameter int MAC_W = 2
) (
  input  logic                      decide_i,
  input  logic                      mac_en_i,
  input  logic [BB_CLS_W-1:0]       bb_cls_i,
  input  logic [MAC_W-1:0]          mac_code_i,
  output logic                      mac_go_o,
  output logic [BB_CLS_W+MAC_W-1:0] result_o
);

  logic bb_hung;

  assign bb_hung  = |bb_cls_i;
  assign mac_go_o = decide_i & mac_en_i & ~bb_hung;

  always_comb begin
    result_o = {{MAC_W{1'b0}}, bb_cls_i};
    if (mac_go_o) result_o[BB_CLS_W +: MAC_W] = mac_code_i;
  end

  // R9: the MAC strobe never coexists with a baseband class
  always_comb begin
    a_r9_no_mac_when_hung: assert (!(mac_go_o && bb_hung));
  end

endmodule

// File: rtl/bbh_matcher.sv
module bbh_matcher
  import bbh_pkg::*;
#(
  parameter int NSAMP = 50,
  parameter int MAC_W = 2,
  localparam int RES_W = BB_CLS_W + MAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             bb_en_i,
  input  logic             mac_en_i,
  input  logic [OBS_W-1:0] obs_i,
  input  logic [MAC_W-1:0] mac_code_i,
  output logic             mac_chk_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);

  bbh_state_e state_q, state_d;

  logic             bb_en_q, mac_en_q;
  logic             accept, watch, decide;
  logic             last, steady;
  logic [OBS_W-1:0] held_word;
  logic [BB_CLS_W-1:0] bb_cls;
  logic [RES_W-1:0] result_d, result_q;
  logic             done_q;
  logic             mac_go;

  assign accept = (state_q == ST_IDLE) & req_i;
  assign watch  = (state_q == ST_WATCH);
  assign decide = (state_q == ST_DECIDE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_i) state_d = bb_en_i ? ST_WATCH : ST_DECIDE;
      ST_WATCH:  if (last)  state_d = ST_DECIDE;
      ST_DECIDE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bb_en_q  <= 1'b0;
      mac_en_q <= 1'b0;
    end else if (accept) begin
      bb_en_q  <= bb_en_i;
      mac_en_q <= mac_en_i;
    end
  end

  bbh_window #(
    .OBS_W (OBS_W),
    .NSAMP (NSAMP)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (accept),
    .active_i (watch),
    .obs_i    (obs_i),
    .word_o   (held_word),
    .last_o   (last),
    .steady_o (steady)
  );

  bbh_sig_match u_match (
    .word_i (held_word),
    .en_i   (bb_en_q & steady),
    .cls_o  (bb_cls)
  );

  bbh_combine #(
    .MAC_W (MAC_W)
  ) u_combine (
    .decide_i   (decide),
    .mac_en_i   (mac_en_q),
    .bb_cls_i   (bb_cls),
    .mac_code_i (mac_code_i),
    .mac_go_o   (mac_go),
    .result_o   (result_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (decide) begin
      result_q <= result_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= decide;
  end

  assign mac_chk_o = mac_go;
  assign done_o    = done_q;
  assign result_o  = result_q;

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: a MAC strobe is followed by completion
  a_r10_chk_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    mac_chk_o |=> done_o);

  // R9: a baseband class in the result excludes MAC bits
  a_r9_result_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (result_o[BB_CLS_W-1:0] != '0))
      |-> (result_o[RES_W-1:BB_CLS_W] == '0));

  // R7: the reported baseband class is at most one-hot
  a_r7_result_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $onehot0(result_o[BB_CLS_W-1:0]));

  // R13: a disabled baseband check never reports a class
  a_r13_bb_off: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !bb_en_q) |-> (result_o[BB_CLS_W-1:0] == '0));

  // R12: request flags are frozen while a window runs
  a_r12_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    watch |=> ($stable(bb_en_q) && $stable(mac_en_q)));

endmodule

// File: tb/tb_bbh_matcher.sv
module tb_bbh_matcher;

  localparam int CLK_PERIOD = 10;
  localparam int NSAMP      = 50;
  localparam int NVEC       = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic        bb_en;
  logic        mac_en;
  logic [31:0] obs;
  logic [1:0]  mac_code;
  logic        mac_chk;
  logic        done;
  logic [4:0]  result;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bbh_matcher #(.NSAMP(NSAMP), .MAC_W(2)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .bb_en_i    (bb_en),
    .mac_en_i   (mac_en),
    .obs_i      (obs),
    .mac_code_i (mac_code),
    .mac_chk_o  (mac_chk),
    .done_o     (done),
    .result_o   (result)
  );

  // {bb_en, mac_en, mac_code, glitch_at, word, expected result}
  localparam logic [46:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 2'b11, 6'd0,  32'h1E00_0000, 5'b00001},
    {1'b1, 1'b1, 2'b01, 6'd0,  32'h9E00_54FF, 5'b00001},
    {1'b1, 1'b0, 2'b00, 6'd0,  32'h5200_0B00, 5'b00010},
    {1'b1, 1'b1, 2'b10, 6'd0,  32'h1800_0B00, 5'b00100},
    {1'b1, 1'b0, 2'b00, 6'd0,  32'h0070_2400, 5'b00100},
    {1'b1, 1'b1, 2'b11, 6'd0,  32'h80F0_2410, 5'b00100},
    {1'b1, 1'b1, 2'b10, 6'd0,  32'h1234_5678, 5'b10000},
    {1'b1, 1'b0, 2'b11, 6'd0,  32'h1234_5678, 5'b00000},
    {1'b1, 1'b1, 2'b01, 6'd25, 32'h1E00_0000, 5'b01000},
    {1'b1, 1'b0, 2'b00, 6'd50, 32'h1800_0B00, 5'b00000},
    {1'b1, 1'b1, 2'b11, 6'd1,  32'h0070_2400, 5'b11000},
    {1'b0, 1'b1, 2'b11, 6'd0,  32'h5200_0B00, 5'b11000},
    {1'b0, 1'b0, 2'b10, 6'd0,  32'h1E00_0000, 5'b00000}
  };

  function automatic string vec_tag(input int idx);
    case (idx)
      0, 1:    vec_tag = "R3";
      2:       vec_tag = "R4";
      3:       vec_tag = "R5";
      4, 5:    vec_tag = "R6";
      6:       vec_tag = "R8";
      7:       vec_tag = "R10";
      8, 9, 10: vec_tag = "R2";
      default: vec_tag = "R13";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one check run; optional ignored request at cycle extra_k (0 = none)
  task automatic run_check(input logic b, input logic m, input logic [1:0] code,
                           input int glitch, input logic [31:0] word,
                           input logic [4:0] exp, input string tag, input int extra_k);
    int  lat;
    bit  exp_mac;
    lat     = b ? NSAMP + 1 : 1;
    exp_mac = m && (exp[2:0] == 3'b000);
    @(negedge clk);
    req = 1'b1; bb_en = b; mac_en = m; mac_code = code; obs = word;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    check({tag, "/R10 strobe"}, {31'd0, mac_chk}, {31'd0, exp_mac && lat == 1});
    for (int k = 1; k <= lat; k++) begin
      obs = (glitch == k) ? (word ^ 32'h0000_0001) : word;
      if (extra_k == k) begin
        req = 1'b1; bb_en = 1'b0; mac_en = 1'b0;  // R12: must be ignored
      end
      @(posedge clk);
      @(negedge clk);
      req = 1'b0; bb_en = b; mac_en = m;
      check({tag, "/R11 done"}, {31'd0, done}, {31'd0, k == lat});
      if (k == lat - 1)
        check({tag, "/R10 strobe"}, {31'd0, mac_chk}, {31'd0, exp_mac});
      if (k == lat) begin
        check({tag, "/result"}, {27'd0, result}, {27'd0, exp});
        if (exp[2:0] != 3'b000)
          check({tag, "/R9 mac bits"}, {30'd0, result[4:3]}, 32'd0);
      end
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 100000);
        summary();
      end
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; bb_en = 1'b0; mac_en = 1'b0;
    obs = '0; mac_code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 chk", {31'd0, mac_chk}, 32'd0);
    check("R1 result", {27'd0, result}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      run_check(VEC[i][46], VEC[i][45], VEC[i][44:43], int'(VEC[i][42:37]),
                VEC[i][36:5], VEC[i][4:0], vec_tag(i), 0);
    end

    // R12: request mid-window is ignored
    run_check(1'b1, 1'b1, 2'b11, 0, 32'h1E00_0000, 5'b00001, "R12", 10);
    // R7: first-listed signature decides, class stays single
    run_check(1'b1, 1'b1, 2'b10, 0, 32'hD200_0BFF, 5'b00010, "R7", 0);

    // R1: reset during a window
    @(negedge clk);
    req = 1'b1; bb_en = 1'b1; mac_en = 1'b1; mac_code = 2'b11; obs = 32'h5200_0B00;
    @(negedge clk);
    req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid done", {31'd0, done}, 32'd0);
    check("R1 mid result", {27'd0, result}, 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < NSAMP + 3; k++) begin
      @(negedge clk);
      if (done) begin
        check("R1 no stray done", 32'd1, 32'd0);
        break;
      end
    end
    check("R1 chk idle", {31'd0, mac_chk}, 32'd0);
    summary();
  end

endmodule